// File: doc/BRIEF.md
# Cyclic egress gate scheduler

This block drives the transmission gates of the eight traffic classes on each egress port. Each port owns a table of up to sixteen schedule entries. An entry pairs an 8-bit gate mask with an open interval, and the interval is counted in cycles of the local clock. While a port's enable is low, software loads entries and the index of the final entry through a shared write port, and all eight gates of that port stay open. When the enable goes high, the port starts at entry 0 on the next clock edge. There is no wait for a base time. It then walks the table in order, holds each mask on its gates for that entry's interval, and returns to entry 0 after the final entry. The cycle time is therefore the sum of the active intervals.

Each port reports its active entry index and gives a one-cycle pulse whenever a new entry becomes active. An entry whose interval is zero is a configuration fault, and the port stops in a closed, flagged state. The block also watches all ports at once and flags any clock cycle in which two or more ports have a gate event together, because the schedules must be laid out so that this never happens.

Top module: `gate_sched`

## Requirements
- R1: While a port's enable input is low at a clock edge, after that edge the port's gates are all open (mask 0xFF), its index output is 0 and its event output is 0.
- R2: On the first edge at which a port's enable is sampled high, that port loads entry 0. After that edge its gates show entry 0's mask, its index is 0 and its event output is 1.
- R3: Bit n of the active entry's mask drives gate n of the port, and each entry stays active for exactly as many clock cycles as its interval value (32-bit, unsigned).
- R4: Entries run in ascending index order from 0 to the programmed final index (0 to 15, giving 1 to 16 entries). After the final entry, the port returns to entry 0.
- R5: A port's event output is high for exactly the first cycle of each newly active entry, including the return to entry 0. An entry with interval 1 therefore gives events on back-to-back cycles.
- R6: Writes to a port's entry table or final index are ignored while that port's enable is high. Writes made while the enable is low take effect for the next run.
- R7: If the entry about to become active has interval 0, the port raises its fault output and closes all gates (mask 0x00). It then gives no further events until its enable is sampled low, which clears the fault.
- R8: The clash output is high in exactly those cycles in which the event outputs of two or more ports are high.
- R9: After reset, all gates are open, all indexes, events, faults and the clash output are 0, all stored intervals are 0 and every final index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is one schedule tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | NUM_PORTS | Per-port scheduler enable |
| wr_en_i | input | 1 | Write one table entry of the port selected by wr_port_i |
| wr_port_i | input | PW | Port selected for a table or final-index write |
| wr_idx_i | input | IW | Entry index to write |
| wr_mask_i | input | 8 | Gate mask to write |
| wr_ivl_i | input | IVL_W | Interval to write, in clock cycles |
| last_we_i | input | 1 | Write the final-entry index of the selected port |
| last_i | input | IW | Final-entry index (entry count minus one) |
| gate_o | output | NUM_PORTS*8 | Gate states, port p at bits [8p+7:8p] |
| idx_o | output | NUM_PORTS*IW | Active entry index, port p at bits [IW*p+IW-1:IW*p] |
| evt_o | output | NUM_PORTS | One-cycle gate-event pulse per port |
| cfg_err_o | output | NUM_PORTS | Zero-interval fault per port |
| clash_o | output | 1 | Two or more ports have an event in this cycle |

## Verification
Every gate, index, event and fault output comes from a register. Each result therefore appears right after the edge that samples its cause, which is one cycle after the enable, the write or the end of an interval. The clash output is combinational from the registered events, so it appears in the same cycle as those events. The bench drives inputs at the falling edge and updates its own model of the schedule at the rising edge. It compares every output at the following falling edge, so each expected value lines up with the cycle in which the design produces it.

// File: rtl/gs_pkg.sv
package gs_pkg;
  localparam int unsigned NUM_CLASS = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ERR  = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gs_table.sv
module gs_table
  import gs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IVL_W = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [NUM_CLASS-1:0] wr_mask_i,
  input  logic [IVL_W-1:0]     wr_ivl_i,
  input  logic                 last_we_i,
  input  logic [IW-1:0]        last_i,
  input  logic [IW-1:0]        rd_idx_i,
  output logic [NUM_CLASS-1:0] rd_mask_o,
  output logic [IVL_W-1:0]     rd_ivl_o,
  output logic [IW-1:0]        last_o
);
  logic [NUM_CLASS-1:0] mask_q [DEPTH];
  logic [IVL_W-1:0]     ivl_q  [DEPTH];
  logic [IW-1:0]        last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mask_q[i] <= '0;
        ivl_q[i]  <= '0;
      end
      last_q <= '0;
    end else if (!en_i) begin
      // table is frozen while the port runs
      if (we_i) begin
        mask_q[wr_idx_i] <= wr_mask_i;
        ivl_q[wr_idx_i]  <= wr_ivl_i;
      end
      if (last_we_i) last_q <= last_i;
    end
  end

  assign rd_mask_o = mask_q[rd_idx_i];
  assign rd_ivl_o  = ivl_q[rd_idx_i];
  assign last_o    = last_q;

  assert_table_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && en_i) |=> (ivl_q[$past(wr_idx_i)] == $past(ivl_q[wr_idx_i]) &&
                        mask_q[$past(wr_idx_i)] == $past(mask_q[wr_idx_i])));
  assert_last_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_we_i && en_i) |=> $stable(last_q));
endmodule

// File: rtl/gs_walker.sv
module gs_walker
  import gs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IVL_W = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [IW-1:0]        last_i,
  input  logic [NUM_CLASS-1:0] rd_mask_i,
  input  logic [IVL_W-1:0]     rd_ivl_i,
  output logic [IW-1:0]        rd_idx_o,
  output logic [NUM_CLASS-1:0] gate_o,
  output logic [IW-1:0]        idx_o,
  output logic                 evt_o,
  output logic                 cfg_err_o
);
  gs_state_e            state_q;
  logic [IW-1:0]        idx_q, nxt_idx;
  logic [IVL_W-1:0]     rem_q;
  logic [NUM_CLASS-1:0] mask_q;
  logic                 evt_q;

  always_comb begin
    nxt_idx  = (idx_q == last_i) ? '0 : idx_q + 1'b1;
    rd_idx_o = (state_q == ST_RUN) ? nxt_idx : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      mask_q  <= '0;
      evt_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_RUN: begin
          if (state_q == ST_RUN && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
          end else if (rd_ivl_i == '0) begin
            state_q <= ST_ERR;
          end else begin
            state_q <= ST_RUN;
            idx_q   <= rd_idx_o;
            rem_q   <= rd_ivl_i - 1'b1;
            mask_q  <= rd_mask_i;
            evt_q   <= 1'b1;
          end
        end
        default: state_q <= ST_ERR;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:  gate_o = mask_q;
      ST_ERR:  gate_o = '0;
      default: gate_o = '1;
    endcase
  end

  assign idx_o     = idx_q;
  assign evt_o     = evt_q;
  assign cfg_err_o = (state_q == ST_ERR);

  assert_idle_open_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_o == '1 && !evt_o && idx_o == '0 && !cfg_err_o));
  assert_hold_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_RUN && rem_q != '0) |=>
      ($stable(gate_o) && $stable(idx_o) && !evt_o));
  assert_advance_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_RUN && rem_q == '0) |=>
      (cfg_err_o || (evt_o && idx_o == (($past(idx_o) == $past(last_i)) ? '0 : $past(idx_o) + 1'b1))));
  assert_fault_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && en_i) |=> (cfg_err_o && !evt_o && gate_o == '0));
endmodule

// File: rtl/gs_clash.sv
module gs_clash #(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic [NUM_PORTS-1:0] evt_i,
  output logic                 clash_o
);
  always_comb begin
    int unsigned n;
    n = 0;
    for (int p = 0; p < NUM_PORTS; p++) n += evt_i[p] ? 1 : 0;
    clash_o = (n > 1);
  end

  always_comb begin
    assert_clash_R8: assert (clash_o == ($countones(evt_i) > 1));
  end
endmodule

// File: rtl/gate_sched.sv
module gate_sched
  import gs_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned IVL_W     = 32,
  localparam int unsigned IW       = $clog2(DEPTH),
  localparam int unsigned PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS-1:0]           en_i,
  input  logic                           wr_en_i,
  input  logic [PW-1:0]                  wr_port_i,
  input  logic [IW-1:0]                  wr_idx_i,
  input  logic [NUM_CLASS-1:0]           wr_mask_i,
  input  logic [IVL_W-1:0]               wr_ivl_i,
  input  logic                           last_we_i,
  input  logic [IW-1:0]                  last_i,
  output logic [NUM_PORTS*NUM_CLASS-1:0] gate_o,
  output logic [NUM_PORTS*IW-1:0]        idx_o,
  output logic [NUM_PORTS-1:0]           evt_o,
  output logic [NUM_PORTS-1:0]           cfg_err_o,
  output logic                           clash_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic                 sel;
    logic [IW-1:0]        rd_idx, last;
    logic [NUM_CLASS-1:0] rd_mask;
    logic [IVL_W-1:0]     rd_ivl;

    assign sel = (wr_port_i == PW'(p));

    gs_table #(.DEPTH(DEPTH), .IVL_W(IVL_W)) u_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i[p]),
      .we_i      (wr_en_i && sel),
      .wr_idx_i  (wr_idx_i),
      .wr_mask_i (wr_mask_i),
      .wr_ivl_i  (wr_ivl_i),
      .last_we_i (last_we_i && sel),
      .last_i    (last_i),
      .rd_idx_i  (rd_idx),
      .rd_mask_o (rd_mask),
      .rd_ivl_o  (rd_ivl),
      .last_o    (last)
    );

    gs_walker #(.DEPTH(DEPTH), .IVL_W(IVL_W)) u_walker (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i[p]),
      .last_i    (last),
      .rd_mask_i (rd_mask),
      .rd_ivl_i  (rd_ivl),
      .rd_idx_o  (rd_idx),
      .gate_o    (gate_o[p*NUM_CLASS +: NUM_CLASS]),
      .idx_o     (idx_o[p*IW +: IW]),
      .evt_o     (evt_o[p]),
      .cfg_err_o (cfg_err_o[p])
    );
  end

  gs_clash #(.NUM_PORTS(NUM_PORTS)) u_clash (
    .evt_i   (evt_o),
    .clash_o (clash_o)
  );
endmodule

// File: tb/sim_gate_sched.sv
module sim_gate_sched;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] en = '0;
  logic          wr_en = 1'b0;
  logic [0:0]    wr_port = '0;
  logic [3:0]    wr_idx = '0;
  logic [7:0]    wr_mask = '0;
  logic [31:0]   wr_ivl = '0;
  logic          last_we = 1'b0;
  logic [3:0]    last = '0;
  logic [15:0]   gate;
  logic [7:0]    idx;
  logic [NP-1:0] evt, cfg_err;
  logic          clash;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: 0 idle, 1 running, 2 fault
  logic [7:0]  m_mask [NP][16];
  logic [31:0] m_ivl  [NP][16];
  int          m_last [NP];
  int          m_st   [NP];
  int          m_cur  [NP];
  longint      m_rem  [NP];
  bit          m_evt  [NP];

  always #5 clk = ~clk;

  gate_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(wr_en), .wr_port_i(wr_port),
    .wr_idx_i(wr_idx), .wr_mask_i(wr_mask), .wr_ivl_i(wr_ivl), .last_we_i(last_we),
    .last_i(last), .gate_o(gate), .idx_o(idx), .evt_o(evt), .cfg_err_o(cfg_err),
    .clash_o(clash)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < NP; p++) begin
      logic [7:0] eg;
      eg = (m_st[p] == 0) ? 8'hFF : (m_st[p] == 1) ? m_mask[p][m_cur[p]] : 8'h00;
      chk(gate[p*8 +: 8] == eg, {tag, " R3 gate"}, $sformatf("port%0d", p), gate[p*8 +: 8], eg);
      chk(idx[p*4 +: 4] == 4'(m_cur[p]), {tag, " R4 index"}, $sformatf("port%0d", p),
          idx[p*4 +: 4], m_cur[p]);
      chk(evt[p] == m_evt[p], {tag, " R5 event"}, $sformatf("port%0d", p), evt[p], m_evt[p]);
      chk(cfg_err[p] == (m_st[p] == 2), {tag, " R7 fault"}, $sformatf("port%0d", p),
          cfg_err[p], m_st[p] == 2);
    end
    chk(clash == (m_evt[0] && m_evt[1]), {tag, " R8 clash"}, "clash", clash, m_evt[0] && m_evt[1]);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      if (!en[p]) begin
        m_st[p] = 0; m_cur[p] = 0; m_evt[p] = 0;
      end else if (m_st[p] == 2) begin
        m_evt[p] = 0;
      end else if (m_st[p] == 1 && m_rem[p] > 1) begin
        m_rem[p]--; m_evt[p] = 0;
      end else begin
        int nx;
        nx = (m_st[p] == 0 || m_cur[p] == m_last[p]) ? 0 : m_cur[p] + 1;
        if (m_ivl[p][nx] == 0) begin
          m_st[p] = 2; m_evt[p] = 0;
        end else begin
          m_st[p] = 1; m_cur[p] = nx; m_rem[p] = m_ivl[p][nx]; m_evt[p] = 1;
        end
      end
      if (!en[p] && wr_en && int'(wr_port) == p) begin
        m_mask[p][wr_idx] = wr_mask; m_ivl[p][wr_idx] = wr_ivl;
      end
      if (!en[p] && last_we && int'(wr_port) == p) m_last[p] = last;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr_entry(input int p, input int i, input logic [7:0] m, input logic [31:0] v);
    wr_en = 1'b1; wr_port = 1'(p); wr_idx = 4'(i); wr_mask = m; wr_ivl = v;
    step("R6 write");
    wr_en = 1'b0;
  endtask

  task automatic wr_last(input int p, input int l);
    last_we = 1'b1; wr_port = 1'(p); last = 4'(l);
    step("R6 last");
    last_we = 1'b0;
  endtask

  task automatic run(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  // R9, R1: reset values
  task automatic t_reset;
    for (int p = 0; p < NP; p++) begin
      m_last[p] = 0; m_st[p] = 0; m_cur[p] = 0; m_rem[p] = 0; m_evt[p] = 0;
      for (int i = 0; i < 16; i++) begin m_mask[p][i] = 8'h00; m_ivl[p][i] = 0; end
    end
    @(negedge clk);
    compare("R9 reset");
    rst_n = 1'b1;
    run("R1 disabled", 3);
  endtask

  // R2, R3, R4, R5: two-entry cycle, 3 + 5 cycles
  task automatic t_basic;
    wr_entry(0, 0, 8'h80, 3);
    wr_entry(0, 1, 8'h7F, 5);
    wr_last(0, 1);
    en[0] = 1'b1;
    step("R2 start");
    chk(evt[0] && gate[7:0] == 8'h80 && idx[3:0] == 0, "R2", "first entry",
        {evt[0], gate[7:0]}, {1'b1, 8'h80});
    run("R4 cycle", 20);
  endtask

  // R6: writes while enabled ignored; R1: disable opens gates
  task automatic t_frozen;
    wr_entry(0, 0, 8'h01, 2);
    wr_last(0, 0);
    run("R6 running", 6);
    en[0] = 1'b0;
    step("R1 disable");
    chk(gate[7:0] == 8'hFF, "R1", "gates after disable", gate[7:0], 8'hFF);
    en[0] = 1'b1;
    run("R6 rerun", 12);
    en[0] = 1'b0;
    step("R1 idle");
  endtask

  // R4 full 16-entry table, R5 interval 1, R8 clash between ports
  task automatic t_full;
    for (int i = 0; i < 16; i++) wr_entry(0, i, 8'((1 << (i % 8)) | i), 32'(i % 3 + 1));
    wr_last(0, 15);
    wr_entry(1, 0, 8'hAA, 1);
    wr_last(1, 0);
    en = 2'b11;
    step("R8 start");
    chk(clash == 1'b1, "R8", "both ports start", clash, 1);
    run("R4 full", 40);
    en = 2'b00;
    step("R1 idle");
  endtask

  // R8: single-entry schedules 3 and 4 cycles long clash every 12 cycles
  task automatic t_offset;
    wr_entry(0, 0, 8'h0F, 3);
    wr_last(0, 0);
    wr_entry(1, 0, 8'hF0, 4);
    en = 2'b11;
    run("R8 offset", 30);
    en = 2'b00;
    step("R1 idle");
  endtask

  // R7: zero interval mid-table and at entry 0
  task automatic t_zero;
    wr_entry(1, 0, 8'h11, 2);
    wr_entry(1, 1, 8'h22, 0);
    wr_last(1, 1);
    en[1] = 1'b1;
    run("R7 mid", 3);
    chk(cfg_err[1] && gate[15:8] == 8'h00, "R7", "fault after entry 0",
        {cfg_err[1], gate[15:8]}, {1'b1, 8'h00});
    run("R7 hold", 4);
    en[1] = 1'b0;
    step("R7 clear");
    chk(!cfg_err[1], "R7", "fault cleared", cfg_err[1], 0);
    wr_entry(0, 0, 8'h33, 0);
    en[0] = 1'b1;
    step("R7 first");
    chk(cfg_err[0] && !evt[0], "R7", "fault on entry 0", cfg_err[0], 1);
    run("R7 hold0", 3);
    en[0] = 1'b0;
    step("R1 idle");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_frozen();
    t_full();
    t_offset();
    t_zero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule